// File: doc/BRIEF.md
# Byte-Stream Arithmetic Core Sequencer

This block is a small multi-cycle engine that walks a byte-encoded instruction stream held in a synchronous read-only memory. It decodes and executes one instruction at a time on a bank of 64-bit general registers. Every instruction starts with one opcode byte. The arithmetic instructions then carry a destination byte and an operand byte. The operand byte names the first source register and says whether the second operand comes from the stream as a 32-bit immediate or from a register named by one more byte. Addition, subtraction and multiplication finish in one execute cycle. Unsigned division uses a sequential restoring divider, and the sequencer waits while it runs.

The memory port works one byte at a time: the core drives an address with a read enable, and the byte comes back on the next cycle. After each completed instruction the core pulses a retire strobe and shows the written register and its value. A halt opcode stops the core cleanly. Bad register numbers, a zero divisor and running past the end of the memory stop it with a fault. The halt and fault states remain until reset.

Top module: `bsa_core`

## Requirements
- R1: While reset is asserted, pc equals ROM_BASE and halted, fault and retire are low. After reset, register 0 reads zero and registers 1 to 15 read all ones.
- R2: An arithmetic instruction is the opcode byte, then a destination byte, then an operand byte. Opcodes are 0x02 add, 0x03 subtract, 0x04 multiply and 0x05 divide. In the operand byte, bit 0 set selects an immediate second operand, and bits 7:1 give the first source register.
- R3: With an immediate selected, the next four bytes form the second operand, lowest byte first, and it is zero-extended to 64 bits.
- R4: With bit 0 of the operand byte clear, one more byte follows, and its low 4 bits select the second source register. Its upper bits are ignored.
- R5: Add, subtract and multiply write only the low 64 bits of the true result to the destination.
- R6: Divide is unsigned. A zero divisor raises fault, and no register is written and no retire is signalled for that instruction.
- R7: A destination byte of 0 or 16 and above, or a first source index of 16 and above, raises fault.
- R8: A fetch is never issued at an address at or beyond ROM_BASE+ROM_LEN. Reaching such an address, including in the middle of an instruction, raises fault.
- R9: Opcode 0x01 sets halted. No further fetch or retire occurs until reset.
- R10: Opcode 0x00 and every opcode above 0x05 retire with ret_we low and leave all registers unchanged. Execution goes on at the next byte.
- R11: retire is high for exactly one cycle per completed instruction and carries ret_we, ret_rd and ret_value. Halted and fault are never both high, and each stays high until reset.
- R12: pc rises by one for each byte consumed. When the core stops, pc is the address of the byte after the last one consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rom_en | output | 1 | Read enable for the memory byte at rom_addr |
| rom_addr | output | AW | Byte address of the fetch |
| rom_rdata | input | 8 | Byte returned one cycle after rom_en |
| halted | output | 1 | Clean stop after a halt opcode |
| fault | output | 1 | Stop on an error condition |
| retire | output | 1 | One-cycle pulse per completed instruction |
| ret_we | output | 1 | The retired instruction wrote a register |
| ret_rd | output | IDX_W | Destination register of the retired instruction |
| ret_value | output | XLEN | Value written by the retired instruction |
| pc | output | AW | Address of the next byte to consume |

## Verification
The bench builds the core with XLEN 64, 16 registers, a 16-bit address, ROM_BASE 0x0100 and a ROM_LEN of only 64 bytes. The short memory lets a stream of no-ops reach the end of memory within a few hundred cycles. It also lets an immediate be cut off at the last bytes, so both cases of R8 can be reached. The full 64-bit width runs the divider through all of its iterations and lets the all-ones reset values show overflow wrap in multiply and subtract.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  localparam logic [7:0] OPC_NOP  = 8'h00;
  localparam logic [7:0] OPC_HALT = 8'h01;
  localparam logic [7:0] OPC_ADD  = 8'h02;
  localparam logic [7:0] OPC_SUB  = 8'h03;
  localparam logic [7:0] OPC_MUL  = 8'h04;
  localparam logic [7:0] OPC_DIV  = 8'h05;

  typedef enum logic [3:0] {
    ST_OPC,
    ST_DST,
    ST_SRC,
    ST_IMM,
    ST_RS2,
    ST_EXEC,
    ST_DIVW,
    ST_HALT,
    ST_FAULT
  } seq_state_e;

endpackage

// File: rtl/bsa_regfile.sv
module bsa_regfile #(
  parameter int XLEN = 64,
  parameter int NREG = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [XLEN-1:0]  rd_a_data,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [XLEN-1:0]  rd_b_data
);

  logic [XLEN-1:0] bank_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [XLEN-1:0] RST_VAL = (g == 0) ? '0 : '1;
    logic hit;
    assign hit = we && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[g] <= RST_VAL;
      end else if (hit) begin
        bank_q[g] <= wr_data;
      end
    end
  end

  assign rd_a_data = bank_q[rd_a_idx];
  assign rd_b_data = bank_q[rd_b_idx];

  // R7
  wr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (wr_idx != '0));

  // R1
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q[0] == '0);

endmodule

// File: rtl/bsa_alu.sv
module bsa_alu #(
  parameter int XLEN = 64
) (
  input  logic [7:0]      opc,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  import bsa_pkg::*;

  always_comb begin
    unique case (opc)
      OPC_SUB: y = a - b;
      OPC_MUL: y = a * b;
      default: y = a + b;
    endcase
  end

endmodule

// File: rtl/bsa_divider.sv
module bsa_divider #(
  parameter int XLEN = 64,
  localparam int CNT_W = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] quotient
);

  logic [XLEN:0]   rem_q, rem_d;
  logic [XLEN-1:0] quo_q, quo_d;
  logic [XLEN-1:0] dvs_q, dvs_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic            busy_q, busy_d;
  logic            done_q, done_d;
  logic [XLEN:0]   trial;
  logic [XLEN:0]   diff;

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    trial  = {rem_q[XLEN-1:0], quo_q[XLEN-1]};
    diff   = trial - {1'b0, dvs_q};
    if (start) begin
      rem_d  = '0;
      quo_d  = dividend;
      dvs_d  = divisor;
      cnt_d  = CNT_W'(XLEN - 1);
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (!diff[XLEN]) begin
        rem_d = diff;
        quo_d = {quo_q[XLEN-2:0], 1'b1};
      end else begin
        rem_d = trial;
        quo_d = {quo_q[XLEN-2:0], 1'b0};
      end
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign quotient = quo_q;

  // R6
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q));

endmodule

// File: rtl/bsa_core.sv
module bsa_core #(
  parameter int XLEN = 64,
  parameter int NREG = 16,
  parameter int AW = 16,
  parameter logic [AW-1:0] ROM_BASE = 16'h0100,
  parameter int ROM_LEN = 64,
  parameter int IMM_BYTES = 4,
  localparam int IDX_W = $clog2(NREG),
  localparam int IMM_W = 8 * IMM_BYTES,
  localparam int IBC_W = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1,
  localparam int ROM_END = int'(ROM_BASE) + ROM_LEN
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             rom_en,
  output logic [AW-1:0]    rom_addr,
  input  logic [7:0]       rom_rdata,
  output logic             halted,
  output logic             fault,
  output logic             retire,
  output logic             ret_we,
  output logic [IDX_W-1:0] ret_rd,
  output logic [XLEN-1:0]  ret_value,
  output logic [AW-1:0]    pc
);
  import bsa_pkg::*;

  // reset: asserted at once, released after two edges
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  seq_state_e       state_q, state_d;
  logic             wait_q, wait_d;
  logic [AW-1:0]    pc_q, pc_d;
  logic [7:0]       opc_q, opc_d;
  logic [IDX_W-1:0] dst_q, dst_d;
  logic [IDX_W-1:0] rs1_q, rs1_d;
  logic [IDX_W-1:0] rs2_q, rs2_d;
  logic             imm_sel_q, imm_sel_d;
  logic [IMM_W-1:0] imm_q, imm_d;
  logic [IBC_W-1:0] ibc_q, ibc_d;
  logic             retire_q, retire_d;
  logic             ret_we_q, ret_we_d;
  logic [IDX_W-1:0] ret_rd_q, ret_rd_d;
  logic [XLEN-1:0]  ret_val_q, ret_val_d;

  logic             fetch_state;
  logic             in_range;
  logic             dst_bad;
  logic             src_bad;
  logic             rf_we;
  logic [XLEN-1:0]  rf_wdata;
  logic [XLEN-1:0]  rf_a;
  logic [XLEN-1:0]  rf_b;
  logic [XLEN-1:0]  opb;
  logic [XLEN-1:0]  alu_y;
  logic             div_start;
  logic             div_busy;
  logic             div_done;
  logic [XLEN-1:0]  div_quo;

  bsa_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .we       (rf_we),
    .wr_idx   (dst_q),
    .wr_data  (rf_wdata),
    .rd_a_idx (rs1_q),
    .rd_a_data(rf_a),
    .rd_b_idx (rs2_q),
    .rd_b_data(rf_b)
  );

  assign opb = imm_sel_q ? XLEN'(imm_q) : rf_b;

  bsa_alu #(.XLEN(XLEN)) u_alu (
    .opc(opc_q),
    .a  (rf_a),
    .b  (opb),
    .y  (alu_y)
  );

  bsa_divider #(.XLEN(XLEN)) u_div (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start   (div_start),
    .dividend(rf_a),
    .divisor (opb),
    .busy    (div_busy),
    .done    (div_done),
    .quotient(div_quo)
  );

  assign fetch_state = (state_q == ST_OPC) || (state_q == ST_DST) ||
                       (state_q == ST_SRC) || (state_q == ST_IMM) ||
                       (state_q == ST_RS2);
  assign in_range = (int'(pc_q) < ROM_END);
  assign dst_bad  = (rom_rdata == 8'h00) || (int'(rom_rdata) >= NREG);
  assign src_bad  = (int'(rom_rdata[7:1]) >= NREG);

  always_comb begin
    state_d   = state_q;
    wait_d    = wait_q;
    pc_d      = pc_q;
    opc_d     = opc_q;
    dst_d     = dst_q;
    rs1_d     = rs1_q;
    rs2_d     = rs2_q;
    imm_sel_d = imm_sel_q;
    imm_d     = imm_q;
    ibc_d     = ibc_q;
    retire_d  = 1'b0;
    ret_we_d  = ret_we_q;
    ret_rd_d  = ret_rd_q;
    ret_val_d = ret_val_q;
    rom_en    = 1'b0;
    rf_we     = 1'b0;
    rf_wdata  = alu_y;
    div_start = 1'b0;

    if (fetch_state) begin
      if (!wait_q) begin
        if (!in_range) begin
          state_d = ST_FAULT;
        end else begin
          rom_en = 1'b1;
          wait_d = 1'b1;
        end
      end else begin
        wait_d = 1'b0;
        pc_d   = pc_q + 1'b1;
        unique case (state_q)
          ST_OPC: begin
            opc_d = rom_rdata;
            if (rom_rdata == OPC_HALT) begin
              state_d = ST_HALT;
            end else if (rom_rdata >= OPC_ADD && rom_rdata <= OPC_DIV) begin
              state_d = ST_DST;
            end else begin
              retire_d  = 1'b1;
              ret_we_d  = 1'b0;
              ret_rd_d  = '0;
              ret_val_d = '0;
            end
          end
          ST_DST: begin
            if (dst_bad) begin
              state_d = ST_FAULT;
            end else begin
              dst_d   = rom_rdata[IDX_W-1:0];
              state_d = ST_SRC;
            end
          end
          ST_SRC: begin
            if (src_bad) begin
              state_d = ST_FAULT;
            end else begin
              rs1_d     = rom_rdata[IDX_W:1];
              imm_sel_d = rom_rdata[0];
              imm_d     = '0;
              ibc_d     = '0;
              state_d   = rom_rdata[0] ? ST_IMM : ST_RS2;
            end
          end
          ST_IMM: begin
            imm_d = {rom_rdata, imm_q[IMM_W-1:8]};
            if (ibc_q == IBC_W'(IMM_BYTES - 1)) begin
              state_d = ST_EXEC;
            end else begin
              ibc_d = ibc_q + 1'b1;
            end
          end
          default: begin
            rs2_d   = rom_rdata[IDX_W-1:0];
            state_d = ST_EXEC;
          end
        endcase
      end
    end else if (state_q == ST_EXEC) begin
      if (opc_q == OPC_DIV) begin
        if (opb == '0) begin
          state_d = ST_FAULT;
        end else begin
          div_start = 1'b1;
          state_d   = ST_DIVW;
        end
      end else begin
        rf_we     = 1'b1;
        retire_d  = 1'b1;
        ret_we_d  = 1'b1;
        ret_rd_d  = dst_q;
        ret_val_d = alu_y;
        state_d   = ST_OPC;
      end
    end else if (state_q == ST_DIVW) begin
      rf_wdata = div_quo;
      if (div_done) begin
        rf_we     = 1'b1;
        retire_d  = 1'b1;
        ret_we_d  = 1'b1;
        ret_rd_d  = dst_q;
        ret_val_d = div_quo;
        state_d   = ST_OPC;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q   <= ST_OPC;
      wait_q    <= 1'b0;
      pc_q      <= ROM_BASE;
      opc_q     <= '0;
      dst_q     <= '0;
      rs1_q     <= '0;
      rs2_q     <= '0;
      imm_sel_q <= 1'b0;
      imm_q     <= '0;
      ibc_q     <= '0;
      retire_q  <= 1'b0;
      ret_we_q  <= 1'b0;
      ret_rd_q  <= '0;
      ret_val_q <= '0;
    end else begin
      state_q   <= state_d;
      wait_q    <= wait_d;
      pc_q      <= pc_d;
      opc_q     <= opc_d;
      dst_q     <= dst_d;
      rs1_q     <= rs1_d;
      rs2_q     <= rs2_d;
      imm_sel_q <= imm_sel_d;
      imm_q     <= imm_d;
      ibc_q     <= ibc_d;
      retire_q  <= retire_d;
      ret_we_q  <= ret_we_d;
      ret_rd_q  <= ret_rd_d;
      ret_val_q <= ret_val_d;
    end
  end

  assign rom_addr  = pc_q;
  assign pc        = pc_q;
  assign halted    = (state_q == ST_HALT);
  assign fault     = (state_q == ST_FAULT);
  assign retire    = retire_q;
  assign ret_we    = ret_we_q;
  assign ret_rd    = ret_rd_q;
  assign ret_value = ret_val_q;

  // R8
  rom_range_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    rom_en |-> (int'(rom_addr) < ROM_END && rom_addr >= ROM_BASE));

  // R11
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(halted && fault));

  // R11
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    halted |=> halted);

  // R11
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    fault |=> fault);

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (halted || fault) |-> (!rom_en && !retire));

  // R11
  retire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    retire |=> !retire);

  // R6
  div_wait_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    div_busy |-> !rom_en);

  // R12
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    1'b1 |=> (pc_q == $past(pc_q) || pc_q == $past(pc_q) + 1'b1));

endmodule

// File: tb/sim_bsa_core.sv
module sim_bsa_core;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;
  localparam int NREG = 16;
  localparam int AW = 16;
  localparam logic [AW-1:0] BASE = 16'h0100;
  localparam int LEN = 64;

  typedef struct packed {
    logic        we;
    logic [3:0]  rd;
    logic [63:0] val;
  } ret_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rom_en;
  logic [AW-1:0] rom_addr;
  logic [7:0] rom_rdata = 8'h00;
  logic halted, fault, retire, ret_we;
  logic [3:0] ret_rd;
  logic [XLEN-1:0] ret_value;
  logic [AW-1:0] pc;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  logic [7:0] mem [LEN];
  ret_t exp_q[$];
  bit exp_halt, exp_fault;
  int exp_pc;
  int m_p;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsa_core #(.XLEN(XLEN), .NREG(NREG), .AW(AW), .ROM_BASE(BASE),
             .ROM_LEN(LEN), .IMM_BYTES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .rom_en(rom_en), .rom_addr(rom_addr),
    .rom_rdata(rom_rdata), .halted(halted), .fault(fault),
    .retire(retire), .ret_we(ret_we), .ret_rd(ret_rd),
    .ret_value(ret_value), .pc(pc)
  );

  always @(posedge clk) begin
    if (rom_en) rom_rdata <= mem[(int'(rom_addr) - int'(BASE)) % LEN];
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // retire monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && retire) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_tag, "unexpected retire", ret_value, 64'h0);
      end else begin
        ret_t e;
        e = exp_q.pop_front();
        chk(ret_we == e.we && (!e.we || (ret_rd == e.rd && ret_value == e.val)),
            cur_tag, "retire record", {ret_we, 3'b0, ret_rd, ret_value[55:0]},
            {e.we, 3'b0, e.rd, e.val[55:0]});
        chk(ret_value == e.val, cur_tag, "retire value", ret_value, e.val);
      end
    end
    if (rst_n && (halted || fault) && (rom_en || retire)) begin
      chk(1'b0, "R9", "activity after stop", {62'b0, rom_en, retire}, 64'h0);
    end
  end

  // behavioural reference model
  function automatic int mf();
    int v;
    if (m_p >= LEN) return -1;
    v = int'(mem[m_p]);
    m_p++;
    return v;
  endfunction

  task automatic stop_model(input bit h, input bit f);
    exp_halt = h;
    exp_fault = f;
    exp_pc = int'(BASE) + m_p;
  endtask

  task automatic model_run();
    logic [63:0] x [16];
    int op, d, s, v;
    logic [63:0] a, b, r;
    ret_t e;
    exp_q.delete();
    x[0] = 64'h0;
    for (int i = 1; i < 16; i++) x[i] = '1;
    m_p = 0;
    forever begin
      op = mf();
      if (op < 0) begin stop_model(0, 1); return; end
      if (op == 1) begin stop_model(1, 0); return; end
      if (op == 0 || op > 5) begin
        e.we = 1'b0; e.rd = 4'h0; e.val = 64'h0;
        exp_q.push_back(e);
        continue;
      end
      d = mf();
      if (d < 0 || d == 0 || d >= 16) begin stop_model(0, 1); return; end
      s = mf();
      if (s < 0 || (s >> 1) >= 16) begin stop_model(0, 1); return; end
      a = x[s >> 1];
      if ((s & 1) != 0) begin
        b = 64'h0;
        for (int k = 0; k < 4; k++) begin
          v = mf();
          if (v < 0) begin stop_model(0, 1); return; end
          b = b | (64'(v) << (8 * k));
        end
      end else begin
        v = mf();
        if (v < 0) begin stop_model(0, 1); return; end
        b = x[v % 16];
      end
      case (op)
        2: r = a + b;
        3: r = a - b;
        4: r = a * b;
        default: begin
          if (b == 64'h0) begin stop_model(0, 1); return; end
          r = a / b;
        end
      endcase
      x[d] = r;
      e.we = 1'b1; e.rd = 4'(d); e.val = r;
      exp_q.push_back(e);
    end
  endtask

  task automatic load(input logic [7:0] prog[$], input int at, input logic [7:0] fill);
    for (int i = 0; i < LEN; i++) mem[i] = fill;
    for (int i = 0; i < prog.size(); i++) mem[at + i] = prog[i];
  endtask

  task automatic run_prog(input string tag);
    int cyc;
    bit done;
    model_run();
    rst_n = 1'b0;
    cur_tag = tag;
    repeat (3) @(negedge clk);
    chk(pc == BASE && !halted && !fault && !retire, "R1", "reset state",
        {45'b0, halted, fault, retire, pc}, {48'b0, BASE});
    rst_n = 1'b1;
    cyc = 0;
    done = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (halted || fault) done = 1;
    end
    chk(done, tag, "stop reached", 64'(cyc), 64'd3000);
    chk(halted == exp_halt && fault == exp_fault, tag, "stop kind",
        {62'b0, halted, fault}, {62'b0, exp_halt, exp_fault});
    chk(int'(pc) == exp_pc, "R12", "final pc", 64'(pc), 64'(exp_pc));
    chk(exp_q.size() == 0, tag, "missing retires", 64'(exp_q.size()), 64'h0);
    repeat (4) @(negedge clk);
    chk(halted == exp_halt && fault == exp_fault && !rom_en && !retire, "R11",
        "stop state held", {61'b0, halted, fault, rom_en}, {61'b0, exp_halt, exp_fault, 1'b0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R2 R3 R4 R5 R1: immediate and register forms, wrap, reset values
    load('{8'h02, 8'h01, 8'h01, 8'h78, 8'h56, 8'h34, 8'h12,
           8'h02, 8'h02, 8'h02, 8'h31,
           8'h03, 8'h03, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00,
           8'h04, 8'h04, 8'h0B, 8'hFF, 8'hFF, 8'hFF, 8'hFF,
           8'h02, 8'h06, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00,
           8'h02, 8'h08, 8'h01, 8'h00, 8'h00, 8'h00, 8'h80,
           8'h01}, 0, 8'h00);
    run_prog("R2");
    run_prog("R3");
    // R10: no-op and unknown opcodes
    load('{8'h00, 8'hFF, 8'h06, 8'h02, 8'h01, 8'h01, 8'h05, 8'h00,
           8'h00, 8'h00, 8'h80, 8'h01}, 0, 8'h00);
    run_prog("R10");
    // R6: unsigned divide, then divide by zero register
    load('{8'h05, 8'h01, 8'h0B, 8'h07, 8'h00, 8'h00, 8'h00,
           8'h02, 8'h02, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00,
           8'h05, 8'h03, 8'h02, 8'h02,
           8'h05, 8'h04, 8'h02, 8'h00,
           8'h01}, 0, 8'h00);
    run_prog("R6");
    // R7: destination 0
    load('{8'h02, 8'h00, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00, 8'h01}, 0, 8'h00);
    run_prog("R7");
    // R7: destination 16 after a no-op
    load('{8'h00, 8'h02, 8'h10, 8'h01, 8'h01}, 0, 8'h00);
    run_prog("R7");
    // R7: first source 16
    load('{8'h02, 8'h01, 8'h20, 8'h00, 8'h01}, 0, 8'h00);
    run_prog("R7");
    // R8: run off the end through no-ops
    load('{8'h00}, 0, 8'h00);
    run_prog("R8");
    // R8: immediate cut off by the end of memory
    load('{8'h02, 8'h01, 8'h01, 8'hAA}, LEN - 4, 8'h00);
    run_prog("R8");
    // R9: immediate halt
    load('{8'h01}, 0, 8'h00);
    run_prog("R9");
    // R4: register form with upper bits set in the selector byte
    load('{8'h02, 8'h09, 8'h0E, 8'hF0, 8'h01}, 0, 8'h00);
    run_prog("R4");
    // R5: subtract wrap below zero
    load('{8'h03, 8'h0A, 8'h00, 8'h07, 8'h01}, 0, 8'h00);
    run_prog("R5");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule